// File: doc/BRIEF.md
# Pausable Four-Digit Decimal Counter with Segment Drivers

This block keeps a four-digit decimal count that advances by one at a fixed interval. A clock-enable divider sets the interval, counted in clock cycles. A single pushbutton input passes through a synchronizer and a steady-level filter. Each clean press flips the block between running and paused.

Each digit drives an active-high eight-line segment pattern through its own decoder. The raw BCD digits are also brought out for checking. The decoder handles all sixteen 4-bit codes, so it can be reused as a hexadecimal digit renderer elsewhere.

Top module: `pause_counter_top`

## Requirements
- R1: While `rst_ni` is low, all digits read 0 and the block is running, with the divider phase and the button filter cleared. The reset acts asynchronously.
- R2: Each digit holds a value from 0 to 9. Digit i (i = 0 is the units digit) appears on `bcd_o[4i+3:4i]`.
- R3: While running, the count advances by exactly one every `TICK_CYCLES` clock edges. The first advance happens on the `TICK_CYCLES`-th rising edge after reset is released.
- R4: When a digit at 9 advances, it goes to 0 and advances the next digit. The count 9999 advances to 0000.
- R5: `btn_i` passes through two synchronizing flops. A new level is accepted only after the synchronized value has differed from the accepted level on `DB_CYCLES` consecutive edges. Pulses shorter than that have no effect.
- R6: Each accepted low-to-high change toggles running and paused. Holding the button, or releasing it (even with bounce), causes no further toggle.
- R7: While paused, the digits hold and the divider keeps its phase. After resuming, counting continues from the held value with no count skipped or repeated.
- R8: Segment byte i is `seg_o[8i+7:8i]`. Bits 0 to 6 are segments a to g, and bit 7 is the decimal point. All are active-high, and the decimal point is always 0.
- R9: The decoder maps codes 0 to F to these patterns: 3F 06 5B 4F 66 6D 7D 07 7F 6F 77 7C 39 5E 79 71 (hex, codes in ascending order).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| btn_i | input | 1 | Raw pushbutton level, active-high, may bounce |
| seg_o | output | 8*DIGITS | Segment patterns, one byte per digit |
| bcd_o | output | 4*DIGITS | BCD digit values, units in the low nibble |

## Verification
The hardest case to reach from the ports is the full wrap from 9999 to 0000 when a pause happened mid-interval. The stimulus first pauses and resumes with a bouncing press while the divider is partway through its period. It then lets the block run for more than ten thousand intervals, using a short simulation interval. A reference model checks every cycle, so any lost or duplicated count caused by the pause would surface at the wrap. Glitches shorter than the filter window are injected separately to show that they leave the run state untouched.

// File: rtl/pcnt_pkg.sv
package pcnt_pkg;
  localparam int SEG_W = 8;
  localparam int BCD_W = 4;
  typedef logic [BCD_W-1:0] bcd_t;
  typedef logic [SEG_W-1:0] seg_t;
endpackage

// File: rtl/tick_div.sv
module tick_div #(
  parameter int N = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int W = (N > 1) ? $clog2(N) : 1;

  logic [W-1:0] cnt_q;
  logic         last;

  assign last   = (cnt_q == W'(N - 1));
  assign tick_o = en_i & last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_q <= '0;
    else if (en_i) cnt_q <= last ? '0 : cnt_q + 1'b1;
  end

  // phase frozen while disabled
  assert_phase_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(cnt_q));

  generate
    if (N > 1) begin : g_gap
      assert_tick_gap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/btn_debounce.sv
module btn_debounce #(
  parameter int DB = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic press_o
);
  localparam int CW = $clog2(DB + 1);

  logic          s1_q, s2_q, lvl_q;
  logic [CW-1:0] cnt_q;
  logic          full;

  assign full    = (cnt_q == CW'(DB - 1));
  assign press_o = s2_q & ~lvl_q & full;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q  <= 1'b0;
      s2_q  <= 1'b0;
      lvl_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      s1_q <= raw_i;
      s2_q <= s1_q;
      if (s2_q != lvl_q) begin
        if (full) begin
          lvl_q <= s2_q;
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else begin
        cnt_q <= '0;
      end
    end
  end

  assert_level_gate_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !((s2_q != lvl_q) && full) |=> $stable(lvl_q));
  assert_single_press_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    press_o |=> !press_o && lvl_q);
endmodule

// File: rtl/bcd_digit.sv
module bcd_digit
  import pcnt_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic inc_i,
  output bcd_t val_o,
  output logic carry_o
);
  bcd_t val_q;
  logic top;

  assign top     = (val_q == bcd_t'(9));
  assign carry_o = inc_i & top;
  assign val_o   = val_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    val_q <= '0;
    else if (inc_i) val_q <= top ? '0 : val_q + 1'b1;
  end

  assert_digit_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    val_q <= bcd_t'(9));
  assert_digit_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && val_q != bcd_t'(9)) |=> val_q == $past(val_q) + 4'd1);
  assert_digit_wrap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && val_q == bcd_t'(9)) |=> val_q == '0);
  assert_digit_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inc_i |=> $stable(val_q));
endmodule

// File: rtl/seg_decode.sv
module seg_decode
  import pcnt_pkg::*;
(
  input  bcd_t code_i,
  output seg_t seg_o
);
  logic [6:0] g;  // {g,f,e,d,c,b,a}

  always_comb begin
    unique case (code_i)
      4'h0: g = 7'h3F;
      4'h1: g = 7'h06;
      4'h2: g = 7'h5B;
      4'h3: g = 7'h4F;
      4'h4: g = 7'h66;
      4'h5: g = 7'h6D;
      4'h6: g = 7'h7D;
      4'h7: g = 7'h07;
      4'h8: g = 7'h7F;
      4'h9: g = 7'h6F;
      4'hA: g = 7'h77;
      4'hB: g = 7'h7C;
      4'hC: g = 7'h39;
      4'hD: g = 7'h5E;
      4'hE: g = 7'h79;
      default: g = 7'h71;
    endcase
  end

  assign seg_o = {1'b0, g};
endmodule

// File: rtl/pause_counter_top.sv
module pause_counter_top
  import pcnt_pkg::*;
#(
  parameter int DIGITS      = 4,
  parameter int TICK_CYCLES = 1_000_000,
  parameter int DB_CYCLES   = 20_000
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    btn_i,
  output logic [DIGITS*SEG_W-1:0] seg_o,
  output logic [DIGITS*BCD_W-1:0] bcd_o
);
  logic              run_q;
  logic              press;
  logic              tick;
  logic [DIGITS:0]   inc;

  btn_debounce #(.DB(DB_CYCLES)) u_db (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .raw_i   (btn_i),
    .press_o (press)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    run_q <= 1'b1;
    else if (press) run_q <= ~run_q;
  end

  tick_div #(.N(TICK_CYCLES)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (run_q),
    .tick_o (tick)
  );

  assign inc[0] = tick;

  generate
    for (genvar i = 0; i < DIGITS; i++) begin : g_dig
      bcd_t d;
      bcd_digit u_cnt (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .inc_i   (inc[i]),
        .val_o   (d),
        .carry_o (inc[i+1])
      );
      seg_decode u_dec (
        .code_i (d),
        .seg_o  (seg_o[i*SEG_W +: SEG_W])
      );
      assign bcd_o[i*BCD_W +: BCD_W] = d;
    end
  endgenerate

  assert_pause_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_q |=> $stable(bcd_o));
  assert_toggle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    press |=> run_q != $past(run_q));
  assert_full_wrap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc[DIGITS] |=> bcd_o == '0);
endmodule

// File: tb/sim_pause_counter_top.sv
`timescale 1ns/1ps
module sim_pause_counter_top;
  localparam int DIG  = 4;
  localparam int TICK = 3;
  localparam int DB   = 4;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic btn_i = 1'b0;
  logic [DIG*8-1:0] seg_o;
  logic [DIG*4-1:0] bcd_o;
  logic [3:0] dec_in = '0;
  logic [7:0] dec_out;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  bit saw_9999 = 0, saw_wrap = 0;

  always #2 clk_i = ~clk_i;

  pause_counter_top #(.DIGITS(DIG), .TICK_CYCLES(TICK), .DB_CYCLES(DB)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .btn_i(btn_i), .seg_o(seg_o), .bcd_o(bcd_o)
  );
  seg_decode u_dec (.code_i(dec_in), .seg_o(dec_out));

  function automatic logic [7:0] ref_seg(input int v);
    case (v)
      0: return 8'h3F;  1: return 8'h06;  2: return 8'h5B;  3: return 8'h4F;
      4: return 8'h66;  5: return 8'h6D;  6: return 8'h7D;  7: return 8'h07;
      8: return 8'h7F;  9: return 8'h6F; 10: return 8'h77; 11: return 8'h7C;
     12: return 8'h39; 13: return 8'h5E; 14: return 8'h79; default: return 8'h71;
    endcase
  endfunction

  function automatic logic [15:0] to_bcd(input int v);
    return {4'(v/1000), 4'((v/100)%10), 4'((v/10)%10), 4'(v%10)};
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // reference model
  int m_cnt = 0, m_ph = 0, m_dbc = 0;
  bit m_s1 = 0, m_s2 = 0, m_lvl = 0, m_run = 1;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_cnt = 0; m_ph = 0; m_dbc = 0;
      m_s1 = 0; m_s2 = 0; m_lvl = 0; m_run = 1;
    end else begin
      bit press, tick;
      press = m_s2 && !m_lvl && (m_dbc == DB-1);
      tick  = m_run && (m_ph == TICK-1);
      if (m_s2 != m_lvl) begin
        if (m_dbc == DB-1) begin m_lvl = m_s2; m_dbc = 0; end
        else m_dbc++;
      end else m_dbc = 0;
      m_s2 = m_s1;
      m_s1 = btn_i;
      if (m_run) m_ph = (m_ph == TICK-1) ? 0 : m_ph + 1;
      if (tick)  m_cnt = (m_cnt + 1) % 10000;
      if (press) m_run = !m_run;
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      logic [15:0] eb;
      eb = to_bcd(m_cnt);
      chk(bcd_o == eb, "R2 R3 R4 R5 R6 R7 count", bcd_o, eb);
      for (int i = 0; i < DIG; i++)
        chk(seg_o[i*8 +: 8] == ref_seg(int'(eb[i*4 +: 4])), "R8 segment", seg_o[i*8 +: 8],
            ref_seg(int'(eb[i*4 +: 4])));
      if (bcd_o == 16'h9999) saw_9999 = 1;
      if (saw_9999 && bcd_o == 16'h0000) saw_wrap = 1;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  initial begin
    logic [15:0] snap;
    cyc(3);
    chk(bcd_o == 16'h0 && seg_o == {4{8'h3F}}, "R1 reset state", bcd_o, 0);
    rst_ni = 1'b1;
    cyc(1);
    chk(bcd_o == 16'h0, "R3 no advance before interval", bcd_o, 0);
    cyc(40);
    // short glitch: must be ignored (R5)
    btn_i = 1; cyc(2); btn_i = 0;
    snap = bcd_o; cyc(30);
    chk(bcd_o != snap, "R5 glitch ignored, still running", bcd_o, snap);
    // bouncing press, then held: one toggle to paused (R6)
    cyc(1);
    btn_i = 1; cyc(1); btn_i = 0; cyc(1); btn_i = 1; cyc(1); btn_i = 0; cyc(1);
    btn_i = 1; cyc(15);
    snap = bcd_o; cyc(40);
    chk(bcd_o == snap, "R6 R7 paused while held", bcd_o, snap);
    // bouncing release: no toggle
    btn_i = 0; cyc(1); btn_i = 1; cyc(1); btn_i = 0; cyc(50);
    chk(bcd_o == snap, "R6 release keeps paused", bcd_o, snap);
    // resume
    btn_i = 1; cyc(10); btn_i = 0; cyc(1);
    snap = bcd_o; cyc(30);
    chk(bcd_o != snap, "R7 resumed counting", bcd_o, snap);
    // run through full wrap
    cyc(10000 * TICK + 200);
    chk(saw_9999 && saw_wrap, "R4 9999 wraps to 0000", {saw_9999, saw_wrap}, 2'b11);
    // asynchronous reset mid-run
    #1 rst_ni = 1'b0; #0.5;
    chk(bcd_o == 16'h0, "R1 async reset clears", bcd_o, 0);
    cyc(2); rst_ni = 1'b1; cyc(TICK + 1);
    chk(bcd_o == 16'h1, "R1 R3 running after reset", bcd_o, 1);
    // decoder covers all codes
    for (int v = 0; v < 16; v++) begin
      dec_in = 4'(v); #1;
      chk(dec_out == ref_seg(v), "R9 decoder code", dec_out, ref_seg(v));
      chk(dec_out[7] == 1'b0, "R8 decimal point off", dec_out[7], 0);
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
      $finish;
    end
  end
endmodule